// File: doc/BRIEF.md
# Flash Command Status and Mode Registers

This block is the software-visible face of a flash command controller. A command engine reports its activity through single-cycle event pulses: a command start, a command done, and, alongside done, a success flag. The block turns those pulses into a read-only status word, and keeps a read/write mode word that holds an interrupt enable. Software polls the status word or waits for the interrupt line. Reading the status word acknowledges the completion flags it returned.

Run tracking is a two-state machine. `ST_IDLE` waits for a command. The transition *launch* (start pulse) moves it to `ST_RUN`. The transition *finish* (done pulse while running) moves it back to `ST_IDLE` and produces a one-cycle completion strobe. The busy bit is high exactly while the machine is in `ST_RUN`. The pass, fail and interrupt flags are sticky. A read of the status address clears them one cycle later, and the value returned by that read is the value before clearing. If a completion lands in the same cycle as a clearing read, the completion wins.

Top module: `fsr_flash_status`

## Requirements
- R1: After reset, a read of the status address (0xFFFF0E00) returns 0x0020, a read of the mode address (0xFFFF0E04) returns 0x0000, and `irq_o` is low.
- R2: Status bit 2 (busy) rises in the cycle after a `cmd_start` pulse taken in idle. It falls in the cycle after a `cmd_done` pulse taken while running.
- R3: Status bit 0 (pass) is set in the cycle after a completion with `cmd_ok` high. It then stays set until a status read.
- R4: Status bit 1 (fail) is set in the cycle after a completion with `cmd_ok` low. It then stays set until a status read.
- R5: Status bit 3 (interrupt) is set on a completion only if mode bit 3 (interrupt enable) is 1 in that cycle. With the enable at 0, completions leave bit 3 unchanged.
- R6: A status read returns the current flags and clears bits 0, 1 and 3 in the following cycle. Busy is not affected by the read.
- R7: When a completion and a clearing status read fall in the same cycle, the flag that the completion sets is 1 afterwards.
- R8: `irq_o` always equals status bit 3. It stays high until a status read.
- R9: All 16 mode bits are stored on a write to the mode address and read back unchanged. Reads of any other address return 0 and clear nothing. `bus_rdata` is 0 when `bus_rd` is low.
- R10: Status bit 5 always reads 1. Bit 4 and bits 15:6 always read 0. A write to the status address changes nothing.
- R11: A `cmd_done` pulse in idle is ignored. A `cmd_start` pulse while running is ignored. When start and done arrive together while running, the command finishes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Register address |
| bus_rd | input | 1 | Read strobe; the status read clears the flags |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, same cycle as `bus_rd` |
| cmd_start | input | 1 | Command start pulse from the engine |
| cmd_done | input | 1 | Command completion pulse from the engine |
| cmd_ok | input | 1 | Success flag, valid with `cmd_done` |
| irq_o | output | 1 | Completion interrupt |

## Verification
The assertions assume that the engine drives `cmd_ok` as a qualifier of `cmd_done` only. They also assume that the bus never reads and writes the same register in one cycle with conflicting intent. The stimulus applies reads and writes as separate strobes on a single address. It pulses start and done freely, including out-of-order pulses and coincident pairs, so that the ignore rules of the machine are exercised. The reference model applies the same rule set to every cycle and does not depend on the pulse order.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    localparam int STAT_PASS = 0;
    localparam int STAT_FAIL = 1;
    localparam int STAT_BUSY = 2;
    localparam int STAT_IRQ  = 3;
    localparam int STAT_ONE  = 5;
    localparam int MODE_IE   = 3;
    localparam int FLAG_N    = 3;
endpackage

// File: rtl/fsr_run_fsm.sv
module fsr_run_fsm
    import fsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic done_i,
    output logic busy_o,
    output logic finish_o
);
    run_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_RUN;   // launch
            ST_RUN:  if (done_i)  state_d = ST_IDLE;  // finish
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy_o   = 1'b0;
        finish_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o   = 1'b0;
                finish_o = 1'b0;
            end
            ST_RUN: begin
                busy_o   = 1'b1;
                finish_o = done_i;
            end
            default: begin
                busy_o   = 1'b0;
                finish_o = 1'b0;
            end
        endcase
    end

    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));
    // R11
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && done_i) |=> !busy_o);
endmodule

// File: rtl/fsr_sticky_bit.sv
module fsr_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);
    // R6
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);
    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o && !clr_i) |=> q_o);
endmodule

// File: rtl/fsr_mode_reg.sv
module fsr_mode_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q_o <= '0;
        else if (wr_i) q_o <= wdata_i;
    end

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(q_o));
    // R9
    mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (q_o == $past(wdata_i)));
endmodule

// File: rtl/fsr_flash_status.sv
module fsr_flash_status
    import fsr_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          DATA_W    = 16,
    parameter logic [31:0] STAT_ADDR = 32'hFFFF_0E00,
    parameter logic [31:0] MODE_ADDR = 32'hFFFF_0E04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cmd_start,
    input  logic              cmd_done,
    input  logic              cmd_ok,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] STAT_A = STAT_ADDR[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] MODE_A = MODE_ADDR[ADDR_W-1:0];

    logic              hit_stat, hit_mode, stat_rd, mode_wr;
    logic              busy, finish;
    logic [DATA_W-1:0] mode_q;
    logic [DATA_W-1:0] stat_word;
    logic [FLAG_N-1:0] flag_set;
    logic [FLAG_N-1:0] flag_q;

    assign hit_stat = (bus_addr == STAT_A);
    assign hit_mode = (bus_addr == MODE_A);
    assign stat_rd  = bus_rd && hit_stat;
    assign mode_wr  = bus_wr && hit_mode;

    fsr_run_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (cmd_start),
        .done_i   (cmd_done),
        .busy_o   (busy),
        .finish_o (finish)
    );

    fsr_mode_reg #(.DATA_W(DATA_W)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (mode_wr),
        .wdata_i (bus_wdata),
        .q_o     (mode_q)
    );

    // flag 0: pass, flag 1: fail, flag 2: interrupt
    assign flag_set[0] = finish && cmd_ok;
    assign flag_set[1] = finish && !cmd_ok;
    assign flag_set[2] = finish && mode_q[MODE_IE];

    for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
        fsr_sticky_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (flag_set[g]),
            .clr_i (stat_rd),
            .q_o   (flag_q[g])
        );
    end

    always_comb begin
        stat_word            = '0;
        stat_word[STAT_PASS] = flag_q[0];
        stat_word[STAT_FAIL] = flag_q[1];
        stat_word[STAT_BUSY] = busy;
        stat_word[STAT_IRQ]  = flag_q[2];
        stat_word[STAT_ONE]  = 1'b1;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (hit_stat)      bus_rdata = stat_word;
            else if (hit_mode) bus_rdata = mode_q;
        end
    end

    assign irq_o = flag_q[2];

    // R5
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(mode_q[MODE_IE]));
    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !stat_rd) |=> irq_o);
    // R4
    fail_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[1]) |-> $past(cmd_done && !cmd_ok));
    // R10
    const_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit_stat) |-> (bus_rdata[STAT_ONE] && !bus_rdata[4]));
endmodule

// File: tb/fsr_flash_status_test.sv
`timescale 1ns/1ps
module fsr_flash_status_test;
    localparam logic [31:0] SA = 32'hFFFF_0E00;
    localparam logic [31:0] MA = 32'hFFFF_0E04;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        cmd_start = 1'b0, cmd_done = 1'b0, cmd_ok = 1'b0;
    logic        irq_o;

    int total = 0;
    int bad = 0;

    // behavioural model state
    bit          m_busy, m_pass, m_fail, m_irq;
    logic [15:0] m_mode;

    always #2.5 clk = ~clk;

    fsr_flash_status uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmd_start(cmd_start), .cmd_done(cmd_done), .cmd_ok(cmd_ok), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_rdata();
        logic [15:0] w;
        w = 16'h0020;
        w[0] = m_pass; w[1] = m_fail; w[2] = m_busy; w[3] = m_irq;
        if (!bus_rd)         return 16'h0;
        if (bus_addr == SA)  return w;
        if (bus_addr == MA)  return m_mode;
        return 16'h0;
    endfunction

    // model update on each edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0; m_pass = 0; m_fail = 0; m_irq = 0; m_mode = '0;
        end else begin
            bit fin, rd;
            fin = m_busy && cmd_done;
            rd  = bus_rd && (bus_addr == SA);
            if (fin && cmd_ok)       m_pass = 1; else if (rd) m_pass = 0;
            if (fin && !cmd_ok)      m_fail = 1; else if (rd) m_fail = 0;
            if (fin && m_mode[3])    m_irq  = 1; else if (rd) m_irq  = 0;
            if (m_busy) begin
                if (cmd_done) m_busy = 0;
            end else if (cmd_start) m_busy = 1;
            if (bus_wr && bus_addr == MA) m_mode = bus_wdata;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [15:0] e;
            e = exp_rdata();
            if (bus_rd && bus_addr == SA) begin
                chk("R2 busy", {15'h0, bus_rdata[2]}, {15'h0, e[2]});
                chk("R3 pass", {15'h0, bus_rdata[0]}, {15'h0, e[0]});
                chk("R4 fail", {15'h0, bus_rdata[1]}, {15'h0, e[1]});
                chk("R5 irq bit", {15'h0, bus_rdata[3]}, {15'h0, e[3]});
                chk("R10 fixed bits", bus_rdata & 16'hFFF0, 16'h0020);
            end else begin
                chk("R9 rdata", bus_rdata, e);
            end
            chk("R8 irq_o", {15'h0, irq_o}, {15'h0, m_irq});
        end
    end

    task automatic idle_in();
        bus_rd = 0; bus_wr = 0; cmd_start = 0; cmd_done = 0; cmd_ok = 0;
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic rd_stat_peek(output logic [15:0] v);
        bus_addr = SA; bus_rd = 1; #0.5; v = bus_rdata;
    endtask

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        // R1 reset values
        bus_addr = SA; bus_rd = 1; #0.5;
        chk("R1 status reset", bus_rdata, 16'h0020);
        chk("R1 irq reset", {15'h0, irq_o}, 16'h0);
        bus_addr = MA; #0.5;
        chk("R1 mode reset", bus_rdata, 16'h0000);
        step(); idle_in();

        // R11 done in idle is ignored
        cmd_done = 1; cmd_ok = 1; step(); idle_in(); step();
        rd_stat_peek(v); chk("R11 done in idle", v, 16'h0020);
        step(); idle_in();

        // R2/R3: run, pass, interrupt disabled
        cmd_start = 1; step(); idle_in();
        rd_stat_peek(v); chk("R2 busy after start", v & 16'h0004, 16'h0004);
        bus_rd = 0;
        cmd_start = 1; step(); idle_in();           // R11 start while running
        cmd_done = 1; cmd_ok = 1; step(); idle_in();
        rd_stat_peek(v); chk("R3 pass set, R5 no irq", v, 16'h0021);
        step(); idle_in();
        rd_stat_peek(v); chk("R6 cleared after read", v, 16'h0020);
        step(); idle_in();

        // R5/R4: enable interrupt, fail outcome
        bus_addr = MA; bus_wr = 1; bus_wdata = 16'hA5A8; step(); idle_in();
        bus_addr = MA; bus_rd = 1; #0.5; chk("R9 mode readback", bus_rdata, 16'hA5A8);
        step(); idle_in();
        bus_addr = SA; bus_wr = 1; bus_wdata = 16'hFFFF; step(); idle_in();
        rd_stat_peek(v); chk("R10 status write ignored", v, 16'h0020);
        bus_rd = 0;
        cmd_start = 1; step(); idle_in();
        cmd_done = 1; step(); idle_in();
        chk("R8 irq_o raised", {15'h0, irq_o}, 16'h1);
        rd_stat_peek(v); chk("R4 fail and R5 irq", v, 16'h002A);
        step(); idle_in();
        chk("R6 irq cleared", {15'h0, irq_o}, 16'h0);

        // R7: completion coincides with clearing read
        cmd_start = 1; step(); idle_in();
        cmd_done = 1; cmd_ok = 1; bus_addr = SA; bus_rd = 1; step(); idle_in();
        rd_stat_peek(v); chk("R7 set wins over read", v, 16'h0029);
        step(); idle_in();

        // R11 start and done together while running
        cmd_start = 1; step(); idle_in();
        cmd_start = 1; cmd_done = 1; cmd_ok = 1; step(); idle_in();
        rd_stat_peek(v); chk("R11 start+done finishes", v & 16'h0004, 16'h0000);
        step(); idle_in();

        // R9 other address: zero and no clear
        cmd_start = 1; step(); idle_in();
        cmd_done = 1; cmd_ok = 1; step(); idle_in();
        bus_addr = 32'hFFFF_0E08; bus_rd = 1; #0.5; chk("R9 unmapped read", bus_rdata, 16'h0);
        step(); idle_in();
        rd_stat_peek(v); chk("R9 unmapped read no clear", v & 16'h0001, 16'h0001);
        step(); idle_in();

        // mixed traffic
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            cmd_start = ($urandom_range(0, 4) == 0);
            cmd_done  = ($urandom_range(0, 4) == 0);
            cmd_ok    = $urandom_range(0, 1);
            if (r < 15)      begin bus_addr = SA; bus_rd = 1; end
            else if (r < 20) begin bus_addr = MA; bus_wr = 1; bus_wdata = 16'($urandom); end
            else if (r < 25) begin bus_addr = MA; bus_rd = 1; end
            else if (r < 28) begin bus_addr = SA; bus_wr = 1; bus_wdata = 16'($urandom); end
            else if (r < 30) begin bus_addr = 32'($urandom); bus_rd = 1; end
            step(); idle_in();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule